// File: doc/BRIEF.md
# NAND Descriptor DMA Engine

This engine moves one flash data payload between system memory and the flash data path. Software places a four-word buffer descriptor in memory and writes the descriptor's address into a base register. It then starts a data cycle and names the direction. The engine reads the descriptor over its memory port and checks that it owns the descriptor. It then streams the buffer in 64-bit beats: to the flash transmit port when the flash is being written, or from the flash receive port into memory when the flash is being read. At the end it writes the status word back with ownership returned to software.

Completion is reported in a small interrupt status vector. Bit 6 means a transmit (flash write) transfer finished. Bit 7 means a receive (flash read) transfer finished. Bit 8 means the fetched descriptor was not owned by the engine. All bits clear when the next transfer is accepted. Only one descriptor is handled per start. The second buffer pointer in the descriptor is read but never used.

The memory port carries one access per granted request. Read data is returned in the same cycle as the grant. Both flash ports use valid/ready handshakes.

Top module: `nand_desc_dma`

## Requirements
- R1: A register write at byte offset 0x18 loads the descriptor base address. Writes at any other offset leave the base unchanged.
- R2: After start, the engine reads the descriptor words at base, base+4, base+8 and base+12, in that order. The word at base is the status, the word at base+4 holds the sizes, and the word at base+8 is buffer pointer 0. A read request holds its address until it is granted.
- R3: If status bit 31 of the fetched descriptor is 0, the engine sets int_status bit 8 and returns to idle. It moves no data and does not write to memory.
- R4: In transmit direction (dir=0), beat k is read from memory at pointer0 + 8k and presented on the transmit port. The beat stays valid and unchanged until the flash side is ready.
- R5: In receive direction (dir=1), beat k accepted from the receive port is written to memory at pointer0 + 8k.
- R6: The number of beats is the size field, bits 11:0 of the sizes word, divided by 8 and rounded up. Bits 31:12 of the sizes word are ignored.
- R7: A size field of zero moves no data beats. The transfer still writes the status back and raises the completion bit.
- R8: After the last beat, the engine writes the fetched status word back to the base address with bit 31 cleared and all other bits kept. The upper 32 data bits are written as zero.
- R9: A finished transmit transfer sets int_status bit 6, and a finished receive transfer sets bit 7. A newly accepted start clears int_status.
- R10: The value of buffer pointer 1 (the word at base+12) never becomes a data address.
- R11: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| start | input | 1 | Start a data cycle (sampled when idle) |
| dir | input | 1 | 0 = flash write (transmit), 1 = flash read (receive) |
| busy | output | 1 | Transfer in progress |
| int_status | output | 9 | Bit 6 transmit done, bit 7 receive done, bit 8 descriptor not owned |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_gnt | input | 1 | Memory grants the request this cycle |
| mem_rdata | input | 64 | Read data, valid with the grant |
| fl_tx_valid | output | 1 | Transmit beat valid |
| fl_tx_data | output | 64 | Transmit beat data |
| fl_tx_ready | input | 1 | Flash accepts transmit beat |
| fl_rx_valid | input | 1 | Receive beat valid |
| fl_rx_data | input | 64 | Receive beat data |
| fl_rx_ready | output | 1 | Engine accepts receive beat |

## Verification
Transfers are run in both directions with free-flowing handshakes and with periodic stalls on the memory grant, the transmit ready and the receive valid. The stalls separate correct holding of addresses and beats from designs that drop or repeat data. Size fields of 32, 24, 13 (rounds up), zero, and a value with junk in the upper sizes bits separate correct beat counting from off-by-one and unmasked-width errors. An unowned descriptor, a non-matching register offset, a changed base address and a second start during a transfer check the ownership, decoding and busy-lockout rules. Every memory read address, write address and data word, and every transmit beat, is compared in order against a scoreboard.

// File: rtl/nand_desc_dma.sv
module nand_desc_dma #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int SIZE_W   = 12,
  parameter int REG_AW   = 12,
  parameter logic [REG_AW-1:0] BASE_OFS = 12'h018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              start,
  input  logic              dir,
  output logic              busy,
  output logic [8:0]        int_status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fl_tx_valid,
  output logic [DATA_W-1:0] fl_tx_data,
  input  logic              fl_tx_ready,
  input  logic              fl_rx_valid,
  input  logic [DATA_W-1:0] fl_rx_data,
  output logic              fl_rx_ready
);
  localparam int BEAT_B = DATA_W / 8;
  localparam int SHIFT  = $clog2(BEAT_B);
  localparam int BEAT_W = SIZE_W + 1 - SHIFT;
  localparam int OWN    = 31;
  localparam int TX_BIT = 6;
  localparam int RX_BIT = 7;
  localparam int ND_BIT = 8;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_TXRD, S_TXPUSH, S_RX, S_WB} state_t;

  state_t              state;
  logic [ADDR_W-1:0]   base_q, ptr_q;
  logic [1:0]          idx_q;
  logic [31:0]         stat_q;
  logic [SIZE_W-1:0]   size_q;
  logic                dir_q;
  logic [BEAT_W-1:0]   beat_q;
  logic [DATA_W-1:0]   buf_q;
  logic [SIZE_W:0]     size_rnd;
  logic [BEAT_W-1:0]   nbeats;
  logic                last_beat;

  assign size_rnd  = {1'b0, size_q} + (SIZE_W+1)'(BEAT_B - 1);
  assign nbeats    = BEAT_W'(size_rnd >> SHIFT);
  assign last_beat = (beat_q + 1'b1) == nbeats;

  assign busy        = state != S_IDLE;
  assign fl_tx_valid = state == S_TXPUSH;
  assign fl_tx_data  = buf_q;
  assign fl_rx_ready = (state == S_RX) && mem_gnt;
  assign mem_req     = (state == S_FETCH) || (state == S_TXRD) || (state == S_WB) ||
                       ((state == S_RX) && fl_rx_valid);
  assign mem_we      = (state == S_RX) || (state == S_WB);
  assign mem_wdata   = (state == S_WB) ? DATA_W'({1'b0, stat_q[30:0]}) : fl_rx_data;

  always_comb begin
    case (state)
      S_FETCH:     mem_addr = base_q + ADDR_W'({idx_q, 2'b00});
      S_TXRD, S_RX: mem_addr = ptr_q + (ADDR_W'(beat_q) << SHIFT);
      default:     mem_addr = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (reg_wr && reg_addr == BASE_OFS) begin
      base_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ptr_q      <= '0;
      idx_q      <= '0;
      stat_q     <= '0;
      size_q     <= '0;
      dir_q      <= 1'b0;
      beat_q     <= '0;
      buf_q      <= '0;
      int_status <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          dir_q      <= dir;
          idx_q      <= '0;
          int_status <= '0;
          state      <= S_FETCH;
        end
        S_FETCH: if (mem_gnt) begin
          idx_q <= idx_q + 1'b1;
          case (idx_q)
            2'd0: stat_q <= mem_rdata[31:0];
            2'd1: size_q <= mem_rdata[SIZE_W-1:0];
            2'd2: ptr_q  <= mem_rdata[ADDR_W-1:0];
            default: begin
              beat_q <= '0;
              if (!stat_q[OWN]) begin
                int_status[ND_BIT] <= 1'b1;
                state <= S_IDLE;
              end else if (nbeats == '0) begin
                state <= S_WB;
              end else begin
                state <= dir_q ? S_RX : S_TXRD;
              end
            end
          endcase
        end
        S_TXRD: if (mem_gnt) begin
          buf_q <= mem_rdata;
          state <= S_TXPUSH;
        end
        S_TXPUSH: if (fl_tx_ready) begin
          beat_q <= beat_q + 1'b1;
          state  <= last_beat ? S_WB : S_TXRD;
        end
        S_RX: if (fl_rx_valid && mem_gnt) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state <= S_WB;
        end
        S_WB: if (mem_gnt) begin
          if (dir_q) int_status[RX_BIT] <= 1'b1;
          else       int_status[TX_BIT] <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && !mem_gnt |=> mem_req && $stable(mem_addr));

  assert_unowned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && idx_q == 2'd3 && mem_gnt && !stat_q[OWN]) |=> !busy && int_status[ND_BIT]);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_tx_valid && !fl_tx_ready |=> fl_tx_valid && $stable(fl_tx_data));

  assert_beat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TXRD || state == S_TXPUSH || state == S_RX) |-> beat_q < nbeats);

  assert_flag_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_status));

  assert_start_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && start) |=> busy);
endmodule

// File: tb/nand_desc_dma_tb.sv
module nand_desc_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic        busy;
  logic [8:0]  int_status;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        fl_tx_valid, fl_tx_ready = 1'b1;
  logic [63:0] fl_tx_data;
  logic        fl_rx_valid = 1'b0, fl_rx_ready;
  logic [63:0] fl_rx_data = '0;

  always #5 clk = ~clk;

  nand_desc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .start(start), .dir(dir), .busy(busy), .int_status(int_status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .fl_tx_valid(fl_tx_valid), .fl_tx_data(fl_tx_data), .fl_tx_ready(fl_tx_ready),
    .fl_rx_valid(fl_rx_valid), .fl_rx_data(fl_rx_data), .fl_rx_ready(fl_rx_ready)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rx_k = 0;
  bit stall_mode = 0;
  bit rx_on = 0;
  bit gnt_en = 1;
  logic [31:0] rx_seed = '0;
  logic [31:0] cur_base = '0;

  logic [63:0] dmem [logic [31:0]];
  logic [31:0] rdq[$];
  logic [63:0] txq[$];
  logic [31:0] waq[$];
  logic [63:0] wdq[$];

  assign mem_gnt = mem_req & gnt_en;

  function automatic logic [63:0] rxpat(input logic [31:0] seed, input int k);
    return {seed ^ 32'hA5A5_0F0F, 32'(k) * 32'h0101_0101};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: read data presented from the negative edge
  always @(negedge clk)
    mem_rdata <= dmem.exists(mem_addr) ? dmem[mem_addr] : 64'hDEAD_BEEF_DEAD_BEEF;

  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we) dmem[mem_addr] = mem_wdata;

  // stimulus patterns
  always @(posedge clk) begin
    #1;
    cyc++;
    gnt_en      = !stall_mode || (cyc % 3 != 0);
    fl_tx_ready = !stall_mode || (cyc % 4 != 1);
    fl_rx_valid = rx_on && (!stall_mode || (cyc % 5 != 2));
    fl_rx_data  = rxpat(rx_seed, rx_k);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_gnt && !mem_we) begin
        if (rdq.size() == 0) chk(0, "R2/R10 unexpected read", 64'(mem_addr), 0);
        else begin
          logic [31:0] e;
          e = rdq.pop_front();
          chk(mem_addr == e, "R2/R4/R10 read address", 64'(mem_addr), 64'(e));
        end
      end
      if (fl_tx_valid && fl_tx_ready) begin
        if (txq.size() == 0) chk(0, "R4 unexpected tx beat", fl_tx_data, 0);
        else begin
          logic [63:0] e;
          e = txq.pop_front();
          chk(fl_tx_data == e, "R4 tx data", fl_tx_data, e);
        end
      end
      if (mem_req && mem_gnt && mem_we) begin
        if (waq.size() == 0) chk(0, "R3/R5 unexpected write", 64'(mem_addr), 0);
        else begin
          logic [31:0] ea;
          logic [63:0] ed;
          ea = waq.pop_front();
          ed = wdq.pop_front();
          chk(mem_addr == ea, "R5/R8 write address", 64'(mem_addr), 64'(ea));
          chk(mem_wdata == ed, "R5/R8 write data", mem_wdata, ed);
        end
      end
      if (fl_rx_valid && fl_rx_ready) rx_k++;
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic xfer(input bit d, input logic [31:0] status, input logic [31:0] sizes,
                      input logic [31:0] ptr0, input logic [31:0] ptr1, input bit stall,
                      input bit restart, input string tag);
    int nb;
    int w;
    logic [8:0] exp_int;
    nb = (int'(sizes[11:0]) + 7) / 8;
    dmem[cur_base]      = {32'h0, status};
    dmem[cur_base + 4]  = {32'h0, sizes};
    dmem[cur_base + 8]  = {32'h0, ptr0};
    dmem[cur_base + 12] = {32'h0, ptr1};
    dmem[ptr1] = 64'hBAD0_BAD0_BAD0_BAD0;
    for (int i = 0; i < 4; i++) rdq.push_back(cur_base + 32'(4 * i));
    if (status[31]) begin
      for (int k = 0; k < nb; k++) begin
        if (!d) begin
          dmem[ptr0 + 32'(8 * k)] = {ptr0 ^ 32'h5A5A_0000, 32'(k) ^ 32'h0000_C3C3};
          rdq.push_back(ptr0 + 32'(8 * k));
          txq.push_back({ptr0 ^ 32'h5A5A_0000, 32'(k) ^ 32'h0000_C3C3});
        end else begin
          waq.push_back(ptr0 + 32'(8 * k));
          wdq.push_back(rxpat(ptr0, k));
        end
      end
      waq.push_back(cur_base);
      wdq.push_back({32'h0, status & 32'h7FFF_FFFF});
      exp_int = d ? 9'h080 : 9'h040;
    end else begin
      exp_int = 9'h100;
    end
    @(posedge clk); #1;
    stall_mode = stall; rx_seed = ptr0; rx_k = 0; rx_on = d;
    start = 1; dir = d;
    @(posedge clk); #1;
    start = 0;
    if (restart) begin
      repeat (5) @(posedge clk);
      #1; start = 1; dir = ~d;
      @(posedge clk); #1;
      start = 0;
      @(negedge clk);
      chk(busy == 1'b1, "R11 busy after ignored start", 64'(busy), 1);
    end
    w = 0;
    while (busy && w < 20000) begin
      @(posedge clk); w++;
    end
    @(negedge clk);
    rx_on = 0;
    chk(!busy, {tag, " transfer ends"}, 64'(busy), 0);
    chk(int_status == exp_int, {tag, " int_status (R3/R7/R9)"}, 64'(int_status), 64'(exp_int));
    chk(rdq.size() == 0 && txq.size() == 0 && waq.size() == 0, {tag, " scoreboard drained"},
        64'(rdq.size() + txq.size() + waq.size()), 0);
    if (!status[31])
      chk(dmem[cur_base] == {32'h0, status}, "R3 status untouched", dmem[cur_base], {32'h0, status});
    rdq.delete(); txq.delete(); waq.delete(); wdq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && int_status == 0 && !mem_req && !fl_tx_valid && !fl_rx_ready,
        "reset state", {52'h0, busy, mem_req, fl_tx_valid, int_status}, 0);
    rst_n = 1;
    // R1: base via offset 0x18, other offset ignored
    reg_write(12'h018, 32'h0000_1000);
    reg_write(12'h01C, 32'h0000_5000);
    cur_base = 32'h0000_1000;
    xfer(0, 32'h8000_000C, 32'd32, 32'h0001_0000, 32'h0003_0000, 0, 0, "R1 R4 tx 4 beats");
    xfer(0, 32'h8000_000C, 32'd24, 32'h0001_1000, 32'h0003_0100, 1, 0, "R4 tx stalled");
    xfer(1, 32'h8000_000C, 32'd40, 32'h0002_0000, 32'h0003_0200, 1, 0, "R5 rx stalled");
    xfer(1, 32'h8000_000C, 32'd13, 32'h0002_1000, 32'h0003_0300, 0, 0, "R6 rx rounds up");
    xfer(1, 32'h8000_000C, 32'hFFFF_F010, 32'h0002_2000, 32'h0003_0400, 1, 0, "R6 upper size bits");
    xfer(0, 32'h8000_000C, 32'd0, 32'h0001_2000, 32'h0003_0500, 0, 0, "R7 tx zero size");
    xfer(1, 32'h8000_000C, 32'd0, 32'h0002_3000, 32'h0003_0600, 1, 0, "R7 rx zero size");
    xfer(0, 32'h0000_000C, 32'd32, 32'h0001_3000, 32'h0003_0700, 0, 0, "R3 unowned tx");
    xfer(1, 32'h0123_400C, 32'd16, 32'h0002_4000, 32'h0003_0800, 0, 0, "R3 unowned rx");
    xfer(0, 32'h8765_432C, 32'd64, 32'h0001_4000, 32'h0003_0900, 1, 1, "R11 R8 restart ignored");
    reg_write(12'h018, 32'h0000_2000);
    cur_base = 32'h0000_2000;
    xfer(1, 32'hC000_000C, 32'd8, 32'h0002_5000, 32'h0003_0A00, 0, 0, "R1 R8 R10 new base");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule